// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit turns an interrupt number into a jump to its handler for a 16-bit CPU. The vector table lives in byte-addressable memory, and each interrupt owns a three-byte slot in it. The first byte of a slot is a gate byte, and only the value 0xFF lets the interrupt through. The other two bytes hold the handler address.

The unit reads the slot one byte per cycle. If the CPU is not yet inside a handler, the unit asks the frame sequencer to push a zero argument count and then to save the full register frame. After that it loads the instruction pointer with the handler address. If the CPU is already inside a handler, no frame is saved and only the instruction pointer is reloaded. A return-from-interrupt pulse clears the in-handler state and asks the sequencer to restore the frame.

The table is expected to be filled by other means.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `in_handler`, `busy`, `mem_rd`, `argc_push`, `frame_save`, `ip_load` and `frame_restore` are all 0.
- R2: A dispatch of interrupt number N reads byte address TBL_BASE + 3*N, then +1, then +2, on consecutive cycles. Read data arrives on `mem_rdata` one cycle after `mem_rd`.
- R3: If the gate byte at offset 0 is not 0xFF, the dispatch stops after that single read. There is no push, no save and no `ip_load`, and `in_handler` keeps its value.
- R4: The handler address is little-endian: the byte at offset +1 is bits 7:0 and the byte at offset +2 is bits 15:8. It appears on `ip_value` while `ip_load` is 1.
- R5: When not in a handler, `argc_push` is raised first and held until `seq_ack`. Then `frame_save` is raised and held until `seq_ack`. Then `ip_load` pulses for one cycle, and `in_handler` is 1 on the next cycle.
- R6: When already in a handler, neither `argc_push` nor `frame_save` is raised. `ip_load` pulses directly and `in_handler` stays 1.
- R7: A request while `int_en` is 0 is ignored: no memory read, no `busy`, no output activity.
- R8: An `iret` pulse clears `in_handler` and raises `frame_restore` for exactly one cycle, both on the following cycle.
- R9: A request that arrives while a dispatch is running is held, one deep, and dispatched right after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Interrupt request pulse |
| irq_num | input | 8 | Interrupt number |
| int_en | input | 1 | Interrupt-enable flag from the flags register |
| iret | input | 1 | Return-from-interrupt pulse |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| argc_push | output | 1 | Request to push a zero argument count |
| frame_save | output | 1 | Request for a full frame save |
| seq_ack | input | 1 | Frame sequencer acknowledge |
| ip_load | output | 1 | Load the instruction pointer |
| ip_value | output | 16 | Handler address |
| frame_restore | output | 1 | Request for a frame restore |
| in_handler | output | 1 | CPU is executing a handler |
| busy | output | 1 | Dispatch running or request held |

## Verification
The hardest case to reach is a second request that lands while the first dispatch is still waiting on the frame sequencer. Only then does the held request run as a nested dispatch, without any frame save. The bench delays each sequencer acknowledge by a few cycles and pulses a second request during that window. It then expects the full save sequence for the first number, followed by a bare reload for the second. The boundary checks are a gate byte of 0xFE, the highest interrupt number, and a request made with interrupts disabled.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int          AW       = 16,
  parameter int          NW       = 8,
  parameter logic [15:0] TBL_BASE = 16'h0100,
  parameter logic [7:0]  GATE_ON  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [NW-1:0] irq_num,
  input  logic          int_en,
  input  logic          iret,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          argc_push,
  output logic          frame_save,
  input  logic          seq_ack,
  output logic          ip_load,
  output logic [AW-1:0] ip_value,
  output logic          frame_restore,
  output logic          in_handler,
  output logic          busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_LO, S_HI, S_CHK, S_PUSH, S_SAVE, S_LOAD
  } st_t;

  st_t           st;
  logic          pend;
  logic [NW-1:0] pend_num;
  logic [AW-1:0] entry;
  logic [7:0]    lo_q;
  logic [AW-1:0] hdl_q;

  wire req_ok    = irq_req && int_en;
  wire idle      = (st == S_IDLE);
  wire start     = idle && !iret && (pend || req_ok);
  wire [NW-1:0] sel_num = pend ? pend_num : irq_num;
  wire gate_open = (mem_rdata == GATE_ON);

  wire [AW-1:0] sel_entry = AW'(TBL_BASE) + AW'(sel_num) + AW'({sel_num, 1'b0});

  assign mem_rd     = (st == S_GATE) || (st == S_LO && gate_open) || (st == S_HI);
  assign mem_addr   = (st == S_LO) ? entry + AW'(1) :
                      (st == S_HI) ? entry + AW'(2) : entry;
  assign argc_push  = (st == S_PUSH);
  assign frame_save = (st == S_SAVE);
  assign ip_load    = (st == S_LOAD);
  assign ip_value   = hdl_q;
  assign busy       = !idle || pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      entry    <= '0;
      lo_q     <= '0;
      hdl_q    <= '0;
      pend     <= 1'b0;
      pend_num <= '0;
    end else begin
      if (start) begin
        entry <= sel_entry;
        if (pend) begin
          pend     <= req_ok;
          pend_num <= irq_num;
        end
      end else if (req_ok && !pend) begin
        pend     <= 1'b1;
        pend_num <= irq_num;
      end
      unique case (st)
        S_IDLE: if (start) st <= S_GATE;
        S_GATE: st <= S_LO;
        S_LO:   st <= gate_open ? S_HI : S_IDLE;
        S_HI:   begin lo_q <= mem_rdata; st <= S_CHK; end
        S_CHK:  begin
                  hdl_q <= {mem_rdata, lo_q};
                  st    <= in_handler ? S_LOAD : S_PUSH;
                end
        S_PUSH: if (seq_ack) st <= S_SAVE;
        S_SAVE: if (seq_ack) st <= S_LOAD;
        S_LOAD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_handler    <= 1'b0;
      frame_restore <= 1'b0;
    end else begin
      frame_restore <= iret;
      if (iret)         in_handler <= 1'b0;
      else if (ip_load) in_handler <= 1'b1;
    end
  end

  p_rd_consec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + AW'(1));

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    argc_push && !seq_ack |=> argc_push);

  p_push_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_save) |-> $past(argc_push) && $past(seq_ack));

  p_set_hdl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load && !iret |=> in_handler);

  p_no_nest_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(argc_push) |-> !in_handler);

  p_iret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iret |=> !in_handler && frame_restore);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({argc_push, frame_save, ip_load, mem_rd}));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(irq_req && int_en) |=> !mem_rd);
endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_req = 1'b0, int_en = 1'b0, iret = 1'b0, seq_ack = 1'b0;
  logic [7:0] irq_num = '0, mem_rdata = '0;
  logic mem_rd, argc_push, frame_save, ip_load, frame_restore, in_handler, busy;
  logic [15:0] mem_addr, ip_value;

  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [2:0] K_RD = 3'd0, K_ARGC = 3'd1, K_SAVE = 3'd2,
                         K_LOAD = 3'd3, K_REST = 3'd4;

  logic [7:0]  mem [1024];
  logic [18:0] expq [$];
  int checks = 0, errors = 0, cyc = 0, dly = 0;

  always #2.5 clk = ~clk;

  irq_dispatch u_irq_dispatch (
    .clk, .rst_n, .irq_req, .irq_num, .int_en, .iret, .mem_rd, .mem_addr,
    .mem_rdata, .argc_push, .frame_save, .seq_ack, .ip_load, .ip_value,
    .frame_restore, .in_handler, .busy);

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

  always @(posedge clk) begin
    #1;
    if (seq_ack) seq_ack = 1'b0;
    else if (argc_push || frame_save) begin
      dly = dly + 1;
      if (dly == 3) begin seq_ack = 1'b1; dly = 0; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic observe(input logic [2:0] k, input logic [15:0] v);
    logic [18:0] e;
    if (expq.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3/R7 unexpected event actual %h expected none", {k, v});
    end else begin
      e = expq.pop_front();
      chk("R2/R4/R5/R6/R8 event", {13'd0, k, v}, {13'd0, e});
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd) observe(K_RD, mem_addr);
    if (argc_push && seq_ack) observe(K_ARGC, 16'd0);
    if (frame_save && seq_ack) observe(K_SAVE, 16'd0);
    if (ip_load) observe(K_LOAD, ip_value);
    if (frame_restore) observe(K_REST, 16'd0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic set_entry(input int n, input logic [7:0] g, input logic [15:0] h);
    int a = BASE[9:0] + 3 * n;
    mem[a] = g; mem[a + 1] = h[7:0]; mem[a + 2] = h[15:8];
  endtask

  task automatic expect_disp(input int n, input logic [7:0] g, input logic [15:0] h,
                             input logic nested);
    logic [15:0] a = BASE + 16'(3 * n);
    expq.push_back({K_RD, a});
    if (g == 8'hFF) begin
      expq.push_back({K_RD, a + 16'd1});
      expq.push_back({K_RD, a + 16'd2});
      if (!nested) begin
        expq.push_back({K_ARGC, 16'd0});
        expq.push_back({K_SAVE, 16'd0});
      end
      expq.push_back({K_LOAD, h});
    end
  endtask

  task automatic pulse_req(input int n);
    irq_num = 8'(n); irq_req = 1'b1;
    @(posedge clk); #1; irq_req = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    while (busy) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk("R2-R9 queue drained", expq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    set_entry(5, 8'hFF, 16'h1234);
    set_entry(7, 8'hFF, 16'hBEEF);
    set_entry(9, 8'hFE, 16'h4444);
    set_entry(255, 8'hFF, 16'h5AA5);
    set_entry(3, 8'hFF, 16'h0300);
    set_entry(4, 8'hFF, 16'h0404);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 outputs", {mem_rd, argc_push, frame_save, ip_load, frame_restore, in_handler, busy}, 0);
    rst_n = 1'b1; int_en = 1'b1;
    @(posedge clk); #1;

    // R2 R4 R5: first-level dispatch with frame save
    expect_disp(5, 8'hFF, 16'h1234, 1'b0);
    pulse_req(5); settle();
    chk("R5 in_handler set", in_handler, 1);

    // R6: nested dispatch, no save
    expect_disp(7, 8'hFF, 16'hBEEF, 1'b1);
    pulse_req(7); settle();
    chk("R6 in_handler kept", in_handler, 1);

    // R8: return clears flag, restore pulse
    expq.push_back({K_REST, 16'd0});
    iret = 1'b1; @(posedge clk); #1; iret = 1'b0;
    chk("R8 in_handler cleared", in_handler, 0);
    chk("R8 restore pulse", frame_restore, 1);
    @(posedge clk); #1;
    chk("R8 restore one cycle", frame_restore, 0);
    settle();

    // R3: gate byte 0xFE blocks
    expect_disp(9, 8'hFE, 16'h4444, 1'b0);
    pulse_req(9); settle();
    chk("R3 in_handler unchanged", in_handler, 0);

    // R7: disabled interrupts
    int_en = 1'b0;
    pulse_req(5);
    @(posedge clk); #1;
    chk("R7 not busy", busy, 0);
    settle();
    chk("R7 in_handler unchanged", in_handler, 0);
    int_en = 1'b1;

    // R2 R4: highest number, little-endian address
    expect_disp(255, 8'hFF, 16'h5AA5, 1'b0);
    pulse_req(255); settle();
    expq.push_back({K_REST, 16'd0});
    iret = 1'b1; @(posedge clk); #1; iret = 1'b0;
    settle();

    // R9: request held during dispatch, then nested
    expect_disp(3, 8'hFF, 16'h0300, 1'b0);
    expect_disp(4, 8'hFF, 16'h0404, 1'b1);
    pulse_req(3);
    repeat (6) @(posedge clk); #1;
    chk("R9 busy while held", busy, 1);
    pulse_req(4);
    settle();
    chk("R9 in_handler after pair", in_handler, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule